// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes from a host into frames on a single asynchronous serial line. Each frame is 11 bits long. It has one start bit, eight data bits, a ninth bit and one stop bit. The ninth bit is always sent. It is either a computed odd/even parity bit or a fixed mark/space value.

The host writes into a one-entry holding register. The byte moves into the shift register as soon as the shift register is free. The host can therefore queue the next byte while the current frame is still leaving the block. Two flags report the buffering state. One says the holding register can take a byte. The other says that nothing at all is left to send.

The bit rate comes from an external tick. One bit period equals eight tick pulses. When the tick comes from a reload counter that fires every reload+1 clocks, the bit rate is f/((reload+1)·8). A level-held break control forces the line to the space level. A mode input chooses between an actively driven output and an open-drain style output. The open-drain output only pulls low and otherwise releases the line.

Top module: `ser_tx_top`

## Requirements
- R1: A frame is sent in this order: a start bit of 0, then data bits 0 through 7 (least significant first), then the ninth bit, then a stop bit of 1. Each bit holds for exactly 8 `baud_tick` pulses, counted from the load of the frame.
- R2: With `par_en`=1, the ninth bit makes the number of ones across the eight data bits plus the ninth bit even when `par_even`=1 and odd when `par_even`=0. The control values used are the ones present when the byte enters the shift register.
- R3: With `par_en`=0, the ninth bit equals `par_even`: 1 gives a mark bit and 0 gives a space bit.
- R4: A write while `tx_ready`=1 stores the byte. The byte enters the shift register in the first cycle the shift register is free, or in the same cycle the previous stop bit ends. Consecutive bytes therefore follow with no idle bit time between frames.
- R5: `tx_ready` is 1 exactly when the holding register is empty. It rises in the cycle after the held byte moves into the shift register.
- R6: `tx_idle` is 1 exactly when both the holding register and the shift register are empty.
- R7: A write while `tx_ready`=0 is ignored. The byte already held is the one transmitted next, and `tx_ready` stays 0.
- R8: While `brk`=1, the line is held at the space level (0), whatever the frame state. The frame timing continues underneath the break.
- R9: With `od_mode`=1, `line_out` is always 0 and `line_oe` is 1 only while the level is 0. With `od_mode`=0, `line_oe` is always 1 and `line_out` carries the level.
- R10: After reset, and between frames when `brk`=0, the line is at the mark level (1), with `tx_ready`=1 and `tx_idle`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Byte to send |
| par_en | input | 1 | 1: ninth bit is computed parity; 0: ninth bit is fixed |
| par_even | input | 1 | Even parity (or mark) when 1; odd parity (or space) when 0 |
| brk | input | 1 | Force space level while 1 |
| od_mode | input | 1 | 1: open-drain style output; 0: push-pull output |
| baud_tick | input | 1 | One-cycle pulse; 8 pulses make one bit |
| line_out | output | 1 | Value driven on the serial pin |
| line_oe | output | 1 | Output enable for the serial pin |
| tx_ready | output | 1 | Holding register empty |
| tx_idle | output | 1 | Holding and shift registers both empty |

## Verification
The hardest situation to reach from the ports is the handover at the end of a stop bit. It needs a byte already waiting in the holding register in the very cycle the last tick of the stop bit arrives. A second write must also hit the full holding register at that point. The stimulus fires bursts of two or three writes a few cycles apart, so the second byte waits through a whole frame and the third must be dropped. A behavioural model then follows the line value every cycle, so any gap or lost byte at the frame boundary shows up. Break is also raised in the middle of frames and while idle, in both driver modes.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int DEF_DATA_W        = 8;
    localparam int DEF_TICKS_PER_BIT = 8;

    typedef enum logic {
        DRV_PUSH_PULL  = 1'b0,
        DRV_OPEN_DRAIN = 1'b1
    } drv_mode_e;

    typedef struct packed {
        logic busy;
        logic level;
        logic finishing;
    } shift_stat_t;

    // data_xor is the XOR of all data bits
    function automatic logic ninth_bit(input logic data_xor,
                                       input logic par_en,
                                       input logic par_even);
        if (par_en)
            return par_even ? data_xor : ~data_xor;
        return par_even;
    endfunction

endpackage

// File: rtl/tx_holding.sv
module tx_holding #(
    parameter int DATA_W = ser_tx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= '0;
        end else if (pop) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    assert_full_write_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !pop) |=> (full && $stable(data)));

    assert_pop_frees_R5: assert property (@(posedge clk) disable iff (rst)
        pop |=> !full);

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import ser_tx_pkg::*;
#(
    parameter int DATA_W        = DEF_DATA_W,
    parameter int TICKS_PER_BIT = DEF_TICKS_PER_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              ninth,
    input  logic              baud_tick,
    output shift_stat_t       stat
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int BIT_CW  = $clog2(FRAME_W);
    localparam int SUB_CW  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

    logic [FRAME_W-1:0] sreg;
    logic [BIT_CW-1:0]  bit_cnt;
    logic [SUB_CW-1:0]  sub_cnt;
    logic               busy;
    logic               sub_last;
    logic               bit_last;

    assign sub_last = (sub_cnt == SUB_CW'(TICKS_PER_BIT - 1));
    assign bit_last = (bit_cnt == BIT_CW'(FRAME_W - 1));

    assign stat.busy      = busy;
    assign stat.level     = busy ? sreg[0] : 1'b1;
    assign stat.finishing = busy && baud_tick && sub_last && bit_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sreg    <= '1;
            bit_cnt <= '0;
            sub_cnt <= '0;
        end else if (load) begin
            busy    <= 1'b1;
            sreg    <= {1'b1, ninth, load_data, 1'b0};
            bit_cnt <= '0;
            sub_cnt <= '0;
        end else if (busy && baud_tick) begin
            if (sub_last) begin
                sub_cnt <= '0;
                if (bit_last) begin
                    busy <= 1'b0;
                end else begin
                    sreg    <= {1'b1, sreg[FRAME_W-1:1]};
                    bit_cnt <= bit_cnt + BIT_CW'(1);
                end
            end else begin
                sub_cnt <= sub_cnt + SUB_CW'(1);
            end
        end
    end

    assert_start_bit_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> (stat.busy && !stat.level));

    assert_stop_bit_R1: assert property (@(posedge clk) disable iff (rst)
        stat.finishing |-> stat.level);

    assert_bit_held_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick && !load) |=> $stable(stat.level));

endmodule

// File: rtl/tx_line_drv.sv
module tx_line_drv
    import ser_tx_pkg::*;
(
    input  logic level,
    input  logic brk,
    input  logic od_mode,
    output logic line_out,
    output logic line_oe
);

    drv_mode_e mode;
    logic      pin_level;

    assign mode      = drv_mode_e'(od_mode);
    assign pin_level = brk ? 1'b0 : level;

    always_comb begin
        if (mode == DRV_OPEN_DRAIN) begin
            line_out = 1'b0;
            line_oe  = ~pin_level;
        end else begin
            line_out = pin_level;
            line_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/ser_tx_top.sv
module ser_tx_top
    import ser_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       brk,
    input  logic       od_mode,
    input  logic       baud_tick,
    output logic       line_out,
    output logic       line_oe,
    output logic       tx_ready,
    output logic       tx_idle
);

    localparam int DATA_W = DEF_DATA_W;

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              pop;
    logic              ninth;
    shift_stat_t       stat;

    assign pop   = hold_full && (!stat.busy || stat.finishing);
    assign ninth = ninth_bit(^hold_data, par_en, par_even);

    tx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (pop),
        .full    (hold_full),
        .data    (hold_data)
    );

    tx_shifter #(.DATA_W(DATA_W), .TICKS_PER_BIT(DEF_TICKS_PER_BIT)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (pop),
        .load_data (hold_data),
        .ninth     (ninth),
        .baud_tick (baud_tick),
        .stat      (stat)
    );

    tx_line_drv u_drv (
        .level    (stat.level),
        .brk      (brk),
        .od_mode  (od_mode),
        .line_out (line_out),
        .line_oe  (line_oe)
    );

    assign tx_ready = !hold_full;
    assign tx_idle  = !hold_full && !stat.busy;

    assert_idle_implies_ready_R6: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> tx_ready);

    assert_ready_after_load_R5: assert property (@(posedge clk) disable iff (rst)
        pop |=> tx_ready);

    assert_break_space_R8: assert property (@(posedge clk) disable iff (rst)
        brk |-> (line_oe && !line_out));

    assert_od_never_high_R9: assert property (@(posedge clk) disable iff (rst)
        od_mode |-> !line_out);

    assert_pp_driven_R9: assert property (@(posedge clk) disable iff (rst)
        !od_mode |-> line_oe);

    assert_idle_mark_R10: assert property (@(posedge clk) disable iff (rst)
        (!stat.busy && !brk) |-> (od_mode ? !line_oe : line_out));

    assert_no_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (stat.finishing && hold_full) |=> stat.busy);

endmodule

// File: tb/ser_tx_top_test.sv
module ser_tx_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       par_en = 1'b1;
    logic       par_even = 1'b1;
    logic       brk = 1'b0;
    logic       od_mode = 1'b0;
    logic       baud_tick = 1'b0;
    logic       line_out, line_oe, tx_ready, tx_idle;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int reload = 1;
    int tcnt = 0;

    // reference model state
    bit    m_full = 0;
    bit    m_busy = 0;
    int    m_idx = 0;
    int    m_sub = 0;
    bit    m_frame[11];
    byte   m_hold = 0;
    string m_tag = "R1";
    string m_held_tag = "R4";

    ser_tx_top uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .par_en(par_en), .par_even(par_even), .brk(brk), .od_mode(od_mode),
        .baud_tick(baud_tick), .line_out(line_out), .line_oe(line_oe),
        .tx_ready(tx_ready), .tx_idle(tx_idle)
    );

    always #10 clk = ~clk;

    // reload counter: one tick every reload+1 clocks
    always @(negedge clk) begin
        if (rst) begin
            tcnt = 0;
            baud_tick <= 1'b0;
        end else if (tcnt >= reload) begin
            tcnt = 0;
            baud_tick <= 1'b1;
        end else begin
            tcnt = tcnt + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit calc_ninth(input byte d, input bit pen, input bit pev);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        if (!pen) return pev;
        return pev ? bit'(ones % 2) : bit'(1 - ones % 2);
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_full = 0; m_busy = 0; m_idx = 0; m_sub = 0;
        end else begin
            bit fin;
            bit doload;
            fin = m_busy && baud_tick && m_sub == 7 && m_idx == 10;
            doload = m_full && (!m_busy || fin);
            if (m_busy && baud_tick) begin
                m_sub++;
                if (m_sub == 8) begin
                    m_sub = 0;
                    m_idx++;
                    if (m_idx == 11) m_busy = 0;
                end
            end
            if (doload) begin
                m_frame[0] = 0;
                for (int i = 0; i < 8; i++) m_frame[1+i] = m_hold[i];
                m_frame[9] = calc_ninth(m_hold, par_en, par_even);
                m_frame[10] = 1;
                m_busy = 1; m_idx = 0; m_sub = 0; m_full = 0;
                m_tag = m_held_tag;
            end else if (wr_en) begin
                if (!m_full) begin
                    m_full = 1; m_hold = wr_data; m_held_tag = "R4";
                end else begin
                    m_held_tag = "R7";
                end
            end
        end
    end

    // per-cycle comparison, settled after the edge, before new stimulus
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            bit lvl;
            bit e_out;
            bit e_oe;
            string tag;
            lvl = brk ? 1'b0 : (m_busy ? m_frame[m_idx] : 1'b1);
            if (brk) tag = "R8";
            else if (!m_busy) tag = "R10";
            else if (m_idx == 9) tag = par_en ? "R2" : "R3";
            else if (m_idx >= 1 && m_idx <= 8) tag = (m_tag == "R7") ? "R7" : "R1";
            else tag = "R1";
            e_out = od_mode ? 1'b0 : lvl;
            e_oe  = od_mode ? !lvl : 1'b1;
            check(line_out === e_out, tag, "line_out", line_out, e_out);
            check(line_oe === e_oe, od_mode ? "R9" : tag, "line_oe", line_oe, e_oe);
            check(tx_ready === !m_full, "R5", "tx_ready", tx_ready, !m_full);
            check(tx_idle === (!m_full && !m_busy), "R6", "tx_idle", tx_idle, !m_full && !m_busy);
        end
    end

    task automatic send(input byte b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!tx_idle);
    endtask

    // sample the ninth bit against a fixed expected value
    task automatic check_ninth(input bit exp, input string tag);
        do begin
            @(posedge clk);
            #3;
        end while (!(m_busy && m_idx == 9));
        check(line_out === exp, tag, "ninth bit", line_out, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state, still held in reset
        check(line_out === 1'b1 && line_oe === 1'b1, "R10", "line after reset", line_out, 1);
        check(tx_ready === 1'b1, "R10", "ready after reset", tx_ready, 1);
        check(tx_idle === 1'b1, "R10", "idle after reset", tx_idle, 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R2: computed parity, fixed expectations
        par_en = 1; par_even = 1;
        send(8'h99); check_ninth(1'b0, "R2"); wait_idle();
        par_even = 0;
        send(8'h99); check_ninth(1'b1, "R2"); wait_idle();
        par_even = 1;
        send(8'h07); check_ninth(1'b1, "R2"); wait_idle();
        // R3: mark and space
        par_en = 0; par_even = 1;
        send(8'h00); check_ninth(1'b1, "R3"); wait_idle();
        par_even = 0;
        send(8'hFF); check_ninth(1'b0, "R3"); wait_idle();

        // R4 / R7: queue one, then one more that must be dropped
        par_en = 1; par_even = 1;
        send(8'h55);
        repeat (3) @(negedge clk);
        send(8'hA3);
        repeat (2) @(negedge clk);
        check(tx_ready === 1'b0, "R7", "ready while held", tx_ready, 0);
        send(8'h3C);
        check(tx_ready === 1'b0, "R7", "ready after dropped write", tx_ready, 0);
        wait_idle();

        // R9: open-drain mode, with a break mid-frame (R8)
        od_mode = 1;
        send(8'h5A);
        repeat (40) @(negedge clk);
        brk = 1;
        repeat (37) @(negedge clk);
        brk = 0;
        wait_idle();
        brk = 1;
        repeat (20) @(negedge clk);
        brk = 0;
        od_mode = 0;
        repeat (5) @(negedge clk);

        // slower rate, mixed settings and bursts
        reload = 3;
        for (int n = 0; n < 24; n++) begin
            par_en = 1'($urandom_range(0, 1));
            par_even = 1'($urandom_range(0, 1));
            od_mode = 1'($urandom_range(0, 1));
            send(8'($urandom_range(0, 255)));
            if (n % 3 == 0) begin
                repeat ($urandom_range(0, 5)) @(negedge clk);
                send(8'($urandom_range(0, 255)));
                send(8'($urandom_range(0, 255)));
            end
            if (n % 5 == 2) begin
                repeat ($urandom_range(10, 100)) @(negedge clk);
                brk = 1;
                repeat ($urandom_range(5, 60)) @(negedge clk);
                brk = 0;
            end
            wait_idle();
        end

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule